// File: doc/BRIEF.md
# Per-Branch Local-History Direction Predictor

This block guesses whether a conditional branch will be taken. It uses two levels of state. The first level is a small table of shift registers, each holding the recent outcomes of the branches whose fetch address maps to it. The second level is one shared table of 2-bit saturating counters. The value read from the first level is the index into the second. Because the counter is chosen by the branch's own recent behaviour, a repeating pattern such as taken, not-taken, taken, not-taken gets one counter for each phase and can be predicted without error.

The front end presents a fetch address on the lookup port. In the same cycle it gets back a direction and the counter index that was used. When the branch resolves, the back end returns the address, the real outcome and that saved index on the write port. The block then shifts the outcome into the branch's history entry and trains the counter at the saved index.

Top module: `local_history_predictor`

## Requirements
- R1: After reset every history entry is all zeros and every counter holds weakly-not-taken (2'b01). Every lookup then returns not-taken with index 0.
- R2: The history entry for an address is chosen by address bits [IDX_W+1:2]. Addresses that differ only in other bits share one entry. The lookup reports that entry's content on `lk_index`.
- R3: The lookup direction is taken exactly when the counter at `lk_index` holds 2'b10 or 2'b11. The encoding is 00 strong not-taken, 01 weak not-taken, 10 weak taken, 11 strong taken.
- R4: A write shifts its entry left by one. The oldest bit drops out and the resolved outcome (1 = taken) enters at bit 0. The new value is visible on the lookup port from the next cycle.
- R5: A write moves the counter at `wr_index` one step up on taken and one step down on not-taken. It stays at 2'b11 and 2'b00 at the ends.
- R6: From a strong state, one opposite outcome leaves the prediction unchanged. A second consecutive opposite outcome flips it.
- R7: Training uses the carried `wr_index`, not the current history of `wr_pc`.
- R8: When a lookup and a write hit the same entry in the same cycle, the lookup shows the state from before the write.
- R9: A branch that strictly alternates taken and not-taken is predicted correctly on every lookup once a short warm-up has passed.
- R10: With `wr_valid` low, no history or counter changes, whatever the other write inputs hold.
- R11: Reset is applied asynchronously and released on the clock. Writes presented at the first two rising edges after `rst_n` goes high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assertion |
| lk_pc | input | PC_W | Address of the branch being looked up |
| lk_taken | output | 1 | Predicted direction, 1 = taken |
| lk_index | output | HIST_W | Counter index used for this lookup |
| wr_valid | input | 1 | Resolved branch is presented |
| wr_pc | input | PC_W | Address of the resolved branch |
| wr_taken | input | 1 | Resolved outcome, 1 = taken |
| wr_index | input | HIST_W | Index returned by the lookup of that branch |

## Verification
The lookup and the training write can land in the same cycle, and on the same history entry or counter. The directed phase looks up an address while writing that same address. The random phase draws lookup and write addresses from a small aliasing pool, so collisions happen often. A bench-side model updated only after each clock edge judges every lookup, so the lookup must show the state from before the write, and the written value must appear exactly one cycle later.

// File: rtl/lhp_pkg.sv
package lhp_pkg;

  typedef enum logic [1:0] {
    CTR_STRONG_NT = 2'b00,
    CTR_WEAK_NT   = 2'b01,
    CTR_WEAK_T    = 2'b10,
    CTR_STRONG_T  = 2'b11
  } ctr_t;

  // Saturating one-step move toward the observed outcome.
  function automatic ctr_t ctr_step(input ctr_t cur, input logic taken);
    ctr_t nxt;
    nxt = cur;
    if (taken) begin
      if (cur != CTR_STRONG_T) nxt = ctr_t'(cur + 2'd1);
    end else begin
      if (cur != CTR_STRONG_NT) nxt = ctr_t'(cur - 2'd1);
    end
    return nxt;
  endfunction

endpackage

// File: rtl/lhp_reset_sync.sv
module lhp_reset_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= 2'b00;
    else          sync_q <= sync_d;
  end

  assign rst_n_o = sync_q[1];

endmodule

// File: rtl/lhp_history_table.sv
module lhp_history_table #(
  parameter int PC_W   = 32,
  parameter int IDX_W  = 4,
  parameter int HIST_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PC_W-1:0]   rd_pc,
  output logic [HIST_W-1:0] rd_hist,
  input  logic              wr_en,
  input  logic [PC_W-1:0]   wr_pc,
  input  logic              wr_taken
);

  localparam int DEPTH = 1 << IDX_W;
  localparam int SEL_LO = 2;
  localparam int SEL_HI = IDX_W + 1;

  logic [IDX_W-1:0]  rd_sel;
  logic [IDX_W-1:0]  wr_sel;
  logic [HIST_W-1:0] hist_q [DEPTH];

  assign rd_sel = rd_pc[SEL_HI:SEL_LO];
  assign wr_sel = wr_pc[SEL_HI:SEL_LO];

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    logic              ent_en;
    logic [HIST_W-1:0] ent_d;
    logic [HIST_W-1:0] ent_q;

    always_comb begin
      ent_en = wr_en && (wr_sel == IDX_W'(e));
      ent_d  = {ent_q[HIST_W-2:0], wr_taken};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ent_q <= '0;
      else if (ent_en) ent_q <= ent_d;
    end

    assign hist_q[e] = ent_q;
  end

  assign rd_hist = hist_q[rd_sel];

  // R4: the written entry gains the outcome at bit 0 and keeps its older bits shifted up
  a_r4_hist_shift: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (hist_q[$past(wr_sel)] ==
               {$past(hist_q[wr_sel][HIST_W-2:0]), $past(wr_taken)}));

endmodule

// File: rtl/lhp_counter_table.sv
module lhp_counter_table
  import lhp_pkg::*;
#(
  parameter int HIST_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HIST_W-1:0] rd_idx,
  output logic              rd_taken,
  input  logic              wr_en,
  input  logic [HIST_W-1:0] wr_idx,
  input  logic              wr_taken
);

  localparam int DEPTH = 1 << HIST_W;

  ctr_t cnt_q [DEPTH];

  for (genvar c = 0; c < DEPTH; c++) begin : g_ctr
    logic ctr_en;
    ctr_t ctr_d;
    ctr_t ctr_q;

    always_comb begin
      ctr_en = wr_en && (wr_idx == HIST_W'(c));
      ctr_d  = ctr_step(ctr_q, wr_taken);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ctr_q <= CTR_WEAK_NT;
      else if (ctr_en) ctr_q <= ctr_d;
    end

    assign cnt_q[c] = ctr_q;
  end

  assign rd_taken = cnt_q[rd_idx][1];

  // R5: saturation at the top
  a_r5_sat_high: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_taken && cnt_q[wr_idx] == CTR_STRONG_T)
      |=> (cnt_q[$past(wr_idx)] == CTR_STRONG_T));

  // R5: saturation at the bottom
  a_r5_sat_low: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_taken && cnt_q[wr_idx] == CTR_STRONG_NT)
      |=> (cnt_q[$past(wr_idx)] == CTR_STRONG_NT));

  // R6: one contrary outcome from strong taken keeps the taken prediction
  a_r6_hold_strong: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_taken && cnt_q[wr_idx] == CTR_STRONG_T)
      |=> cnt_q[$past(wr_idx)][1]);

  // R6: one contrary outcome from strong not-taken keeps the not-taken prediction
  a_r6_hold_strong_nt: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_taken && cnt_q[wr_idx] == CTR_STRONG_NT)
      |=> !cnt_q[$past(wr_idx)][1]);

endmodule

// File: rtl/local_history_predictor.sv
module local_history_predictor #(
  parameter int PC_W   = 32,
  parameter int IDX_W  = 4,
  parameter int HIST_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PC_W-1:0]   lk_pc,
  output logic              lk_taken,
  output logic [HIST_W-1:0] lk_index,
  input  logic              wr_valid,
  input  logic [PC_W-1:0]   wr_pc,
  input  logic              wr_taken,
  input  logic [HIST_W-1:0] wr_index
);

  logic              core_rst_n;
  logic [HIST_W-1:0] lk_hist;

  lhp_reset_sync u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (core_rst_n)
  );

  lhp_history_table #(
    .PC_W   (PC_W),
    .IDX_W  (IDX_W),
    .HIST_W (HIST_W)
  ) u_hist (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .rd_pc    (lk_pc),
    .rd_hist  (lk_hist),
    .wr_en    (wr_valid),
    .wr_pc    (wr_pc),
    .wr_taken (wr_taken)
  );

  lhp_counter_table #(
    .HIST_W (HIST_W)
  ) u_ctr (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .rd_idx   (lk_hist),
    .rd_taken (lk_taken),
    .wr_en    (wr_valid),
    .wr_idx   (wr_index),
    .wr_taken (wr_taken)
  );

  assign lk_index = lk_hist;

endmodule

// File: tb/tb_local_history_predictor.sv
`timescale 1ns/1ps
module tb_local_history_predictor;

  localparam int PC_W   = 32;
  localparam int IDX_W  = 4;
  localparam int HIST_W = 4;
  localparam int HDEPTH = 1 << IDX_W;
  localparam int CDEPTH = 1 << HIST_W;

  logic              clk;
  logic              rst_n;
  logic [PC_W-1:0]   lk_pc;
  logic              lk_taken;
  logic [HIST_W-1:0] lk_index;
  logic              wr_valid;
  logic [PC_W-1:0]   wr_pc;
  logic              wr_taken;
  logic [HIST_W-1:0] wr_index;

  int checks;
  int failures;
  bit done;

  logic [HIST_W-1:0] m_hist [HDEPTH];
  logic [1:0]        m_cnt  [CDEPTH];

  local_history_predictor #(.PC_W(PC_W), .IDX_W(IDX_W), .HIST_W(HIST_W)) dut (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(lk_taken),
    .lk_index(lk_index), .wr_valid(wr_valid), .wr_pc(wr_pc),
    .wr_taken(wr_taken), .wr_index(wr_index)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic int sel_of(input logic [PC_W-1:0] pc);
    return int'(pc[IDX_W+1:2]);
  endfunction

  function automatic logic [1:0] step(input logic [1:0] c, input logic t);
    if (t)  return (c == 2'b11) ? 2'b11 : c + 2'd1;
    return (c == 2'b00) ? 2'b00 : c - 2'd1;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < HDEPTH; i++) m_hist[i] = '0;
    for (int i = 0; i < CDEPTH; i++) m_cnt[i] = 2'b01;
  endtask

  // One cycle: drive at negedge, compare lookup against the model, then apply the edge.
  task automatic cycle(input string req, input logic [PC_W-1:0] pc, input logic v,
                       input logic [PC_W-1:0] upc, input logic t, input logic [HIST_W-1:0] ui);
    logic [HIST_W-1:0] ei;
    @(negedge clk);
    lk_pc = pc; wr_valid = v; wr_pc = upc; wr_taken = t; wr_index = ui;
    #1;
    ei = m_hist[sel_of(pc)];
    check({req, " index"}, 32'(lk_index), 32'(ei));
    check({req, " dir"},   32'(lk_taken), 32'(m_cnt[ei][1]));
    @(posedge clk);
    if (v) begin
      m_cnt[ui] = step(m_cnt[ui], t);
      m_hist[sel_of(upc)] = {m_hist[sel_of(upc)][HIST_W-2:0], t};
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [PC_W-1:0] pa, pb, pc_alt, pc_alias;
    int miss;
    void'($urandom(32'h5eed_1234));
    checks = 0; failures = 0; done = 0;
    rst_n = 1'b0; lk_pc = '0; wr_valid = 0; wr_pc = '0; wr_taken = 0; wr_index = '0;
    model_reset();
    repeat (3) @(posedge clk);

    // R11: writes at the first two edges after release are dropped
    pa = 32'h0000_0014;
    @(negedge clk);
    rst_n = 1'b1; wr_valid = 1; wr_pc = pa; wr_taken = 1; wr_index = 4'd3;
    @(posedge clk); @(posedge clk);
    @(negedge clk); wr_valid = 0; lk_pc = pa; #1;
    check("R11 history unchanged", 32'(lk_index), 32'd0);
    check("R11 direction", 32'(lk_taken), 32'd0);

    // R1: reset state seen on several addresses
    for (int i = 0; i < 6; i++) begin
      pb = 32'($urandom) & 32'hFFFF_FFFC;
      cycle("R1 reset lookup", pb, 0, '0, 0, '0);
      check("R1 index zero", 32'(lk_index), 32'd0);
    end

    // R7 / R6: train counter 0 through pa while pb (history still 0) reads it
    pb = 32'h0000_0008;
    cycle("R7 train", pb, 1, pa, 1, 4'd0);
    cycle("R7 train", pb, 1, pa, 1, 4'd0);
    cycle("R7 train", pb, 1, pa, 1, 4'd0);
    @(negedge clk); lk_pc = pb; wr_valid = 0; #1;
    check("R7 counter 0 via carried index", 32'(lk_taken), 32'd1);
    check("R2 untouched entry", 32'(lk_index), 32'd0);
    cycle("R6 first miss", pb, 1, pa, 0, 4'd0);
    @(negedge clk); lk_pc = pb; wr_valid = 0; #1;
    check("R6 still taken after one miss", 32'(lk_taken), 32'd1);
    cycle("R6 second miss", pb, 1, pa, 0, 4'd0);
    @(negedge clk); lk_pc = pb; wr_valid = 0; #1;
    check("R6 flips after two misses", 32'(lk_taken), 32'd0);
    cycle("R5 down", pb, 1, pa, 0, 4'd0);
    cycle("R5 floor", pb, 1, pa, 0, 4'd0);
    cycle("R5 floor hold", pb, 0, pa, 0, 4'd0);

    // R2: alias differing only above the index field shares pa's entry
    pc_alias = pa | 32'h0001_0000;
    @(negedge clk); lk_pc = pc_alias; #1;
    check("R2 alias shares entry", 32'(lk_index), 32'(m_hist[sel_of(pa)]));

    // R8: same-cycle lookup and write on one entry
    cycle("R8 same cycle", pa, 1, pa, 1, 4'd9);
    cycle("R4 visible next cycle", pa, 0, pa, 0, 4'd0);

    // R10: write lines wiggle but valid is low
    for (int i = 0; i < 8; i++)
      cycle("R10 no write", pa, 0, pa, 1'($urandom), 4'($urandom));

    // R9: alternating branch
    pc_alt = 32'h0000_0030;
    miss = 0;
    for (int i = 0; i < 40; i++) begin
      logic o;
      o = (i % 2 == 0);
      @(negedge clk);
      lk_pc = pc_alt; wr_valid = 1; wr_pc = pc_alt; wr_taken = o; #1;
      wr_index = lk_index;
      if (i >= 12) begin
        check("R9 alternating correct", 32'(lk_taken), 32'(o));
      end
      @(posedge clk);
      m_cnt[wr_index] = step(m_cnt[wr_index], o);
      m_hist[sel_of(pc_alt)] = {m_hist[sel_of(pc_alt)][HIST_W-2:0], o};
    end

    // R3 R4 R5 R8: random traffic on an aliasing address pool
    for (int n = 0; n < 3000; n++) begin
      logic [PC_W-1:0] p, u;
      logic [HIST_W-1:0] ix;
      p = (32'($urandom_range(0, 7)) << 2) | (32'($urandom_range(0, 3)) << (IDX_W + 2));
      u = (n % 5 == 0) ? p :
          ((32'($urandom_range(0, 7)) << 2) | (32'($urandom_range(0, 3)) << (IDX_W + 2)));
      ix = ($urandom_range(0, 1) == 1) ? m_hist[sel_of(u)] : 4'($urandom);
      cycle("R3 random", p, 1'($urandom_range(0, 2) != 0), u, 1'($urandom), ix);
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule